// File: doc/BRIEF.md
# Bit-Sliced Integer Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit whose width is a parameter (32 by default). It is built from a chain of identical one-bit slices joined by a ripple carry. Each slice computes AND, OR, a full-adder sum and a pass-through "less" input side by side, and a two-bit select picks one of them. The topmost slice also detects signed overflow and produces the set-on-less-than bit. That bit is routed back to the less input of bit 0.

A four-bit control word `{invert_a, invert_b, sel[1:0]}` chooses the function. Six operations share one datapath. Subtraction inverts B and forces the carry into bit 0 to 1. Set-on-less-than selects the less input of each slice during a subtraction. NOR inverts both operands and takes the AND path. The block has no clock and no state, so the design has no states or transitions to name. The outputs follow the inputs within the same cycle, and the block is meant to sit inside a registered execute stage.

Top module: `bitslice_alu`

## Requirements
- R1: Control code 4'b0000 (AND) gives result = A & B.
- R2: Control code 4'b0001 (OR) gives result = A | B.
- R3: Control code 4'b0010 (add) gives result = (A + B) mod 2^W. carry_out is the carry leaving the top bit.
- R4: Control code 4'b0110 (subtract) gives result = (A - B) mod 2^W. carry_out is 1 exactly when A >= B as unsigned numbers, which means no borrow.
- R5: For add and subtract, overflow is 1 exactly when the operands have the same effective sign and the result sign differs from it. The effective operand for subtract is ~B.
- R6: Control code 4'b0111 (set-on-less-than) gives result = 1 when A < B as signed numbers, and 0 otherwise, with all upper result bits 0. This holds also when A - B overflows.
- R7: Control code 4'b1100 (NOR) gives result = ~(A | B).
- R8: For AND, OR and NOR, overflow and carry_out are 0.
- R9: zero is 1 exactly when every result bit is 0.
- R10: Any other control code gives result 0, overflow 0 and carry_out 0, so zero is 1.
- R11: For set-on-less-than, overflow and carry_out report the A - B subtraction, with the same rules as R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_a | input | WIDTH | First operand |
| operand_b | input | WIDTH | Second operand |
| alu_ctrl | input | 4 | {invert_a, invert_b, sel[1:0]} function code |
| result | output | WIDTH | Selected function result |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of add, subtract or set-on-less-than |
| carry_out | output | 1 | Carry out of the top slice (unsigned overflow, or no-borrow on subtract) |

## Verification
The bench builds the block at the default width of 32. At that width it drives the signed and unsigned boundary values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF through every control code, and compares the outputs with a behavioural model and with hand-derived values. It also builds two copies with WIDTH set to 8. These copies run subtract and set-on-less-than over every one of the 65,536 operand pairs, so every carry pattern through the ripple chain is exercised. This also covers every case where set-on-less-than depends on the overflow correction.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int CTRL_W = 4;
    localparam int SEL_W  = 2;

    typedef enum logic [CTRL_W-1:0] {
        CTRL_AND = 4'b0000,
        CTRL_OR  = 4'b0001,
        CTRL_ADD = 4'b0010,
        CTRL_SUB = 4'b0110,
        CTRL_SLT = 4'b0111,
        CTRL_NOR = 4'b1100
    } alu_ctrl_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    function automatic logic ctrl_listed(input logic [CTRL_W-1:0] code);
        logic ok;
        unique case (code)
            CTRL_AND, CTRL_OR, CTRL_ADD,
            CTRL_SUB, CTRL_SLT, CTRL_NOR: ok = 1'b1;
            default:                      ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic             a_in,
    input  logic             b_in,
    input  logic             a_inv,
    input  logic             b_inv,
    input  logic             carry_in,
    input  logic             less_in,
    input  logic [SEL_W-1:0] sel,
    output logic             res_out,
    output logic             carry_out,
    output logic             sum_out
);

    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff     = a_in ^ a_inv;
        b_eff     = b_in ^ b_inv;
        sum_out   = a_eff ^ b_eff ^ carry_in;
        carry_out = (a_eff & b_eff) | (a_eff & carry_in) | (b_eff & carry_in);
    end

    always_comb begin
        unique case (sel)
            SEL_AND:  res_out = a_eff & b_eff;
            SEL_OR:   res_out = a_eff | b_eff;
            SEL_SUM:  res_out = sum_out;
            SEL_LESS: res_out = less_in;
            default:  res_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic             a_in,
    input  logic             b_in,
    input  logic             a_inv,
    input  logic             b_inv,
    input  logic             carry_in,
    input  logic             less_in,
    input  logic [SEL_W-1:0] sel,
    output logic             res_out,
    output logic             carry_out,
    output logic             ovf_out,
    output logic             set_out
);

    logic sum_bit;
    logic a_sign;
    logic b_sign;

    alu_bit_slice i_core (
        .a_in      (a_in),
        .b_in      (b_in),
        .a_inv     (a_inv),
        .b_inv     (b_inv),
        .carry_in  (carry_in),
        .less_in   (less_in),
        .sel       (sel),
        .res_out   (res_out),
        .carry_out (carry_out),
        .sum_out   (sum_bit)
    );

    always_comb begin
        a_sign  = a_in ^ a_inv;
        b_sign  = b_in ^ b_inv;
        ovf_out = (a_sign == b_sign) && (sum_bit != a_sign);
        set_out = sum_bit ^ ovf_out;
    end

    always_comb begin
        AST_OVF_CARRY_RULE: assert (ovf_out == (carry_in ^ carry_out)); // R5
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32,
    parameter int GROUP = 8
) (
    input  logic [WIDTH-1:0] data,
    output logic             all_zero
);

    localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

    logic [NGRP-1:0] grp_any;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GROUP;
        localparam int HI = ((g + 1) * GROUP > WIDTH) ? WIDTH - 1 : (g + 1) * GROUP - 1;
        assign grp_any[g] = |data[HI:LO];
    end

    assign all_zero = ~|grp_any;

    always_comb begin
        AST_ZERO_FLAG: assert (all_zero == (data == '0)); // R9
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  operand_a,
    input  logic [WIDTH-1:0]  operand_b,
    input  logic [CTRL_W-1:0] alu_ctrl,
    output logic [WIDTH-1:0]  result,
    output logic              zero,
    output logic              overflow,
    output logic              carry_out
);

    localparam int MSB = WIDTH - 1;

    logic             inv_a;
    logic             inv_b;
    logic [SEL_W-1:0] sel;
    logic             listed;
    logic             arith;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] less_vec;
    logic [WIDTH-1:0] slice_res;
    logic             msb_ovf;
    logic             msb_set;

    always_comb begin
        inv_a  = alu_ctrl[3];
        inv_b  = alu_ctrl[2];
        sel    = alu_ctrl[1:0];
        listed = ctrl_listed(alu_ctrl);
        arith  = listed && alu_ctrl[1];
    end

    assign chain[0] = inv_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == 0) begin : g_lsb_less
            assign less_vec[i] = msb_set;
        end else begin : g_hi_less
            assign less_vec[i] = 1'b0;
        end

        if (i == MSB) begin : g_top
            alu_msb_slice i_slice (
                .a_in      (operand_a[i]),
                .b_in      (operand_b[i]),
                .a_inv     (inv_a),
                .b_inv     (inv_b),
                .carry_in  (chain[i]),
                .less_in   (less_vec[i]),
                .sel       (sel),
                .res_out   (slice_res[i]),
                .carry_out (chain[i+1]),
                .ovf_out   (msb_ovf),
                .set_out   (msb_set)
            );
        end else begin : g_body
            logic unused_sum;
            alu_bit_slice i_slice (
                .a_in      (operand_a[i]),
                .b_in      (operand_b[i]),
                .a_inv     (inv_a),
                .b_inv     (inv_b),
                .carry_in  (chain[i]),
                .less_in   (less_vec[i]),
                .sel       (sel),
                .res_out   (slice_res[i]),
                .carry_out (chain[i+1]),
                .sum_out   (unused_sum)
            );
        end
    end

    always_comb begin
        result    = listed ? slice_res : '0;
        overflow  = arith & msb_ovf;
        carry_out = arith & chain[WIDTH];
    end

    alu_zero_detect #(
        .WIDTH (WIDTH)
    ) i_zero (
        .data     (result),
        .all_zero (zero)
    );

    always_comb begin
        if (alu_ctrl == CTRL_ADD) begin
            AST_ADD_SUM: assert ({carry_out, result} == ({1'b0, operand_a} + {1'b0, operand_b})); // R3
        end
        if (alu_ctrl == CTRL_SUB) begin
            AST_SUB_DIFF: assert (result == operand_a - operand_b); // R4
            AST_SUB_NO_BORROW: assert (carry_out == (operand_a >= operand_b)); // R4
        end
        if (alu_ctrl == CTRL_SLT) begin
            AST_SLT_VALUE: assert (result == WIDTH'($signed(operand_a) < $signed(operand_b))); // R6
        end
        if (alu_ctrl == CTRL_AND || alu_ctrl == CTRL_OR || alu_ctrl == CTRL_NOR) begin
            AST_LOGIC_NO_FLAGS: assert (!overflow && !carry_out); // R8
        end
        if (!ctrl_listed(alu_ctrl)) begin
            AST_UNLISTED_QUIET: assert (result == '0 && !overflow && !carry_out && zero); // R10
        end
    end

endmodule

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;

    localparam int W  = 32;
    localparam int WS = 8;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, res;
    logic [3:0]   ctrl;
    logic         zero, ovf, cout;

    logic [WS-1:0] a8, b8, res8s, res8l;
    logic          z8s, z8l, v8s, v8l, c8s, c8l;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bitslice_alu #(.WIDTH(W)) i_bitslice_alu (
        .operand_a(a), .operand_b(b), .alu_ctrl(ctrl),
        .result(res), .zero(zero), .overflow(ovf), .carry_out(cout)
    );

    bitslice_alu #(.WIDTH(WS)) i_bitslice_alu_w8_sub (
        .operand_a(a8), .operand_b(b8), .alu_ctrl(4'b0110),
        .result(res8s), .zero(z8s), .overflow(v8s), .carry_out(c8s)
    );

    bitslice_alu #(.WIDTH(WS)) i_bitslice_alu_w8_slt (
        .operand_a(a8), .operand_b(b8), .alu_ctrl(4'b0111),
        .result(res8l), .zero(z8l), .overflow(v8l), .carry_out(c8l)
    );

    // Behavioural model: returns {result, zero, overflow, carry_out}
    function automatic logic [W+2:0] model(input logic [W-1:0] x, y, input logic [3:0] c);
        logic [W-1:0] r;
        logic [W:0]   s;
        logic         v, co;
        r = '0; v = 1'b0; co = 1'b0;
        case (c)
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b1100: r = ~(x | y);
            4'b0010: begin
                s  = {1'b0, x} + {1'b0, y};
                r  = s[W-1:0];
                co = s[W];
                v  = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'b0110, 4'b0111: begin
                r  = x - y;
                co = (x >= y);
                v  = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
                if (c == 4'b0111) r = W'($signed(x) < $signed(y));
            end
            default: r = '0;
        endcase
        return {r, (r == '0), v, co};
    endfunction

    task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, y, input logic [3:0] c);
        @(posedge clk);
        a = x; b = y; ctrl = c;
        @(negedge clk);
    endtask

    task automatic run_vec(input string tag, input logic [W-1:0] x, y, input logic [3:0] c);
        apply(x, y, c);
        check(tag, {res, zero, ovf, cout}, model(x, y, c));
    endtask

    task automatic t_idle_state;
        apply('0, '0, 4'b0000);
        check("R9 idle AND of zeros", {res, zero, ovf, cout}, {32'h0, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_and_or;
        run_vec("R1 and", 32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000);
        run_vec("R1 and ones", 32'hFFFF_FFFF, 32'h8000_0001, 4'b0000);
        run_vec("R2 or", 32'hF000_0000, 32'h0000_000F, 4'b0001);
        apply(32'h0000_0000, 32'h8000_0000, 4'b0001);
        check("R2 or hand", {res, zero, ovf, cout}, {32'h8000_0000, 1'b0, 1'b0, 1'b0});
    endtask

    task automatic t_add;
        run_vec("R3 add", 32'h1234_5678, 32'h1111_1111, 4'b0010);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
        check("R3 add wrap", {res, zero, ovf, cout}, {32'h0, 1'b1, 1'b0, 1'b1});
        run_vec("R3 add max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010);
    endtask

    task automatic t_sub;
        apply(32'd5, 32'd7, 4'b0110);
        check("R4 sub borrow", {res, zero, ovf, cout}, {32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0});
        apply(32'd7, 32'd5, 4'b0110);
        check("R4 sub no borrow", {res, zero, ovf, cout}, {32'h2, 1'b0, 1'b0, 1'b1});
        run_vec("R4 sub zero minus max", 32'h0, 32'hFFFF_FFFF, 4'b0110);
    endtask

    task automatic t_overflow;
        apply(32'h7FFF_FFFF, 32'h1, 4'b0010);
        check("R5 add pos overflow", {res, zero, ovf, cout}, {32'h8000_0000, 1'b0, 1'b1, 1'b0});
        apply(32'h8000_0000, 32'h8000_0000, 4'b0010);
        check("R5 add neg overflow", {res, zero, ovf, cout}, {32'h0, 1'b1, 1'b1, 1'b1});
        apply(32'h8000_0000, 32'h1, 4'b0110);
        check("R5 sub overflow", {res, zero, ovf, cout}, {32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1});
        run_vec("R5 sub no overflow", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110);
    endtask

    task automatic t_slt;
        apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
        check("R6 R11 slt overflowing sub", {res, zero, ovf, cout}, {32'h1, 1'b0, 1'b1, 1'b1});
        apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
        check("R6 R11 slt reverse", {res, zero, ovf, cout}, {32'h0, 1'b1, 1'b1, 1'b0});
        run_vec("R6 slt minus one vs zero", 32'hFFFF_FFFF, 32'h0, 4'b0111);
        run_vec("R6 slt equal", 32'h1234_0000, 32'h1234_0000, 4'b0111);
        run_vec("R6 slt small", 32'd3, 32'd9, 4'b0111);
    endtask

    task automatic t_nor;
        apply(32'h0F0F_0000, 32'h00F0_00FF, 4'b1100);
        check("R7 nor hand", {res, zero, ovf, cout}, {32'hF000_FF00, 1'b0, 1'b0, 1'b0});
        run_vec("R7 nor ones", 32'hFFFF_FFFF, 32'h0, 4'b1100);
    endtask

    task automatic t_logic_flags;
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0000);
        check("R8 and flags quiet", {ovf, cout}, {1'b0, 1'b0});
        apply(32'hFFFF_FFFF, 32'h8000_0000, 4'b0001);
        check("R8 or flags quiet", {ovf, cout}, {1'b0, 1'b0});
        apply(32'h0, 32'h0, 4'b1100);
        check("R8 nor flags quiet", {ovf, cout}, {1'b0, 1'b0});
    endtask

    task automatic t_zero;
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110);
        check("R9 zero on equal sub", {zero}, {1'b1});
        apply(32'h0000_0001, 32'h0, 4'b0001);
        check("R9 zero clear", {zero}, {1'b0});
    endtask

    task automatic t_unlisted;
        for (int k = 0; k < 16; k++) begin
            if (k == 0 || k == 1 || k == 2 || k == 6 || k == 7 || k == 12) continue;
            apply(32'hA5A5_5A5A, 32'h7FFF_FFFF, 4'(k));
            check($sformatf("R10 unlisted code %0d", k), {res, zero, ovf, cout}, {32'h0, 1'b1, 1'b0, 1'b0});
        end
    endtask

    task automatic t_exhaustive8;
        int bad_s = 0;
        int bad_l = 0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                @(posedge clk);
                a8 = 8'(x); b8 = 8'(y);
                @(negedge clk);
                if (res8s !== 8'(x - y) || c8s !== (x >= y)) begin
                    if (bad_s == 0)
                        $display("FAIL R4 w8 sub a=%0d b=%0d actual=%h/%b expected=%h/%b",
                                 x, y, res8s, c8s, 8'(x - y), (x >= y));
                    bad_s++;
                end
                if (res8l !== 8'($signed(8'(x)) < $signed(8'(y)))) begin
                    if (bad_l == 0)
                        $display("FAIL R6 w8 slt a=%0d b=%0d actual=%h expected=%h",
                                 x, y, res8l, 8'($signed(8'(x)) < $signed(8'(y))));
                    bad_l++;
                end
            end
        end
        checks += 2;
        if (bad_s != 0) fails++;
        if (bad_l != 0) fails++;
    endtask

    initial begin
        a = '0; b = '0; ctrl = '0; a8 = '0; b8 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle_state();
        t_and_or();
        t_add();
        t_sub();
        t_overflow();
        t_slt();
        t_nor();
        t_logic_flags();
        t_zero();
        t_unlisted();
        t_exhaustive8();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule